// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block stores the settings for a set of physical-memory protection entries. Each entry has an 8-bit configuration byte and an address register that is XLEN bits wide. A control-register port reaches these settings in two ways. In configuration space, each index selects a word that holds XLEN/8 consecutive configuration bytes. In address space, each index selects one address register. The block drives every raw configuration byte and every address register out to the region decoders and access checkers downstream. It also gives the number of entries that currently take part in matching.

Every write passes through a lock filter. An entry is frozen when its own lock bit is set. An entry is also frozen when the entry directly above it is locked and uses top-of-range matching, because that neighbour reads the lower entry's address as its own base. Writes that are frozen, out of range or malformed leave no trace and raise no error. Reads are combinational, so data comes back in the same cycle as the index.

Top module: `pmp_regfile`

## Requirements
- R1: After a synchronous active-low reset, all configuration bytes and all address registers are zero, the active count is zero, and no entry is locked.
- R2: A configuration write at word index k stores byte i of the data (bits 8i+7:8i) into entry k·(XLEN/8)+i. Within a byte, bit 7 is the lock bit and bits 4:3 are the match mode: 0 off, 1 top-of-range, 2 four-byte, 3 naturally aligned power of two.
- R3: An entry whose own lock bit is set ignores writes to its configuration byte and to its address register. The lock stays set until reset.
- R4: Entry j also ignores configuration and address writes when entry j+1 has its lock bit set and mode 1. A locked upper neighbour in any other mode does not freeze entry j, and neither does an unlocked neighbour in mode 1.
- R5: The highest entry is frozen only by its own lock bit.
- R6: Within one configuration write, each byte is accepted or rejected by its own entry's lock state alone. Unlocked entries in the same word still update.
- R7: A write to an entry index at or beyond the entry count is ignored. A read of such an index returns zero.
- R8: When XLEN is 64, a configuration write to an odd word index is ignored.
- R9: A configuration read returns the XLEN/8 bytes of the addressed group, with the lowest entry in the lowest byte. An address read returns that entry's register. Both reads are combinational.
- R10: The active count equals the number of entries whose mode field is not 0. A rejected write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Write enable for the addressed word |
| csr_is_addr | input | 1 | 1 selects address registers, 0 selects configuration words |
| csr_idx | input | IDX_W | Word index in the selected space |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_idx |
| entry_cfg | output | N_ENTRIES*8 | Raw configuration bytes, entry j at bits 8j+7:8j |
| entry_addr | output | N_ENTRIES*XLEN | Raw address registers, entry j at slice j |
| active_count | output | CNT_W | Number of entries whose mode is not off |

## Verification
The stimulus uses configuration words that mix every mode in one write, so a byte that lands in the wrong lane or entry shows up when the word is read back. A second pattern places an own-locked off entry, a top-of-range locked entry and an unlocked top entry in one group. Writing all ones to that group then separates per-byte lock filtering from whole-word rejection. Address writes to the entries around that group tell three cases apart: an own lock, a neighbour lock through top-of-range, and a lock that must not propagate, either because the neighbour is in another mode or because the neighbour is unlocked top-of-range. A second 64-bit instance shows that odd-word configuration writes are dropped while even-word writes still land.

// File: rtl/pmp_regfile_pkg.sv
// Shared field positions and mode encoding for the protection entry registers.
// Assumes one 8-bit configuration byte per entry.
package pmp_regfile_pkg;

    localparam int CFG_W    = 8;
    localparam int LOCK_BIT = 7;
    localparam int MODE_LO  = 3;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    // Extract the match mode field from a configuration byte.
    function automatic match_mode_e cfg_mode(input logic [CFG_W-1:0] cfg);
        return match_mode_e'(cfg[MODE_LO +: 2]);
    endfunction

endpackage

// File: rtl/pmp_entry.sv
// One protection entry: a configuration byte and an address register.
// Assumes the caller has already decoded the index. The lock input is the
// entry's effective lock, computed before this cycle's write.
module pmp_entry #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            locked,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wdata,
    input  logic            addr_we,
    input  logic [XLEN-1:0] addr_wdata,
    output logic [7:0]      cfg_q,
    output logic [XLEN-1:0] addr_q
);

    // Configuration byte: cleared on reset, updated only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we && !locked) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Address register: cleared on reset, updated only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_we && !locked) begin
            addr_q <= addr_wdata;
        end
    end

endmodule

// File: rtl/pmp_lock_chain.sv
// Works out the effective lock of every entry from the stored bytes.
// An entry is locked by its own lock bit, or by a locked top-of-range entry
// directly above it. The highest entry has no upper neighbour.
module pmp_lock_chain
    import pmp_regfile_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic [N_ENTRIES*CFG_W-1:0] cfg_flat,
    output logic [N_ENTRIES-1:0]       locked
);

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_lock
        logic own_lock;
        assign own_lock = cfg_flat[j*CFG_W + LOCK_BIT];
        if (j == N_ENTRIES - 1) begin : g_top
            // Highest entry: only its own lock bit applies.
            assign locked[j] = own_lock;
        end else begin : g_mid
            logic [CFG_W-1:0] upper;
            assign upper = cfg_flat[(j+1)*CFG_W +: CFG_W];
            // Own lock, or a locked top-of-range neighbour above.
            assign locked[j] = own_lock
                             | (upper[LOCK_BIT] && (cfg_mode(upper) == MODE_TOR));
        end
    end

endmodule

// File: rtl/pmp_rule_counter.sv
// Counts the entries whose match mode is not off.
// Assumes the count width can hold N_ENTRIES.
module pmp_rule_counter
    import pmp_regfile_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int CNT_W     = 4
) (
    input  logic [N_ENTRIES*CFG_W-1:0] cfg_flat,
    output logic [CNT_W-1:0]           count
);

    // Add one for every entry that takes part in matching.
    always_comb begin
        count = '0;
        for (int j = 0; j < N_ENTRIES; j++) begin
            if (cfg_mode(cfg_flat[j*CFG_W +: CFG_W]) != MODE_OFF) begin
                count = count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pmp_regfile.sv
// Control-register file for the protection entries. It decodes the
// configuration and address spaces, filters writes through the lock chain,
// and serves combinational reads. It also drives the raw settings and the
// active-entry count. Assumes XLEN is 32 or 64.
module pmp_regfile
    import pmp_regfile_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int XLEN      = 32,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       csr_we,
    input  logic                       csr_is_addr,
    input  logic [IDX_W-1:0]           csr_idx,
    input  logic [XLEN-1:0]            csr_wdata,
    output logic [XLEN-1:0]            csr_rdata,
    output logic [N_ENTRIES*CFG_W-1:0] entry_cfg,
    output logic [N_ENTRIES*XLEN-1:0]  entry_addr,
    output logic [CNT_W-1:0]           active_count
);

    localparam int  BPW       = XLEN / CFG_W;
    localparam bit  ODD_BLOCK = (XLEN == 64);

    logic [N_ENTRIES-1:0] entry_locked;
    logic                 cfg_word_ok;
    logic                 cfg_wr;
    logic                 addr_wr;

    // Qualify the two write spaces; 64-bit odd configuration words are dropped.
    always_comb begin
        cfg_word_ok = !(ODD_BLOCK && csr_idx[0]);
        cfg_wr      = csr_we && !csr_is_addr && cfg_word_ok;
        addr_wr     = csr_we && csr_is_addr;
    end

    pmp_lock_chain #(
        .N_ENTRIES (N_ENTRIES)
    ) u_lock (
        .cfg_flat (entry_cfg),
        .locked   (entry_locked)
    );

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_ent
        logic hit_cfg;
        logic hit_addr;
        assign hit_cfg  = cfg_wr  && (int'(csr_idx) == j / BPW);
        assign hit_addr = addr_wr && (int'(csr_idx) == j);

        pmp_entry #(
            .XLEN (XLEN)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .locked     (entry_locked[j]),
            .cfg_we     (hit_cfg),
            .cfg_wdata  (csr_wdata[(j % BPW)*CFG_W +: CFG_W]),
            .addr_we    (hit_addr),
            .addr_wdata (csr_wdata),
            .cfg_q      (entry_cfg[j*CFG_W +: CFG_W]),
            .addr_q     (entry_addr[j*XLEN +: XLEN])
        );
    end

    pmp_rule_counter #(
        .N_ENTRIES (N_ENTRIES),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .cfg_flat (entry_cfg),
        .count    (active_count)
    );

    // Read mux: gather the group's bytes or one address; absent entries read zero.
    always_comb begin
        csr_rdata = '0;
        for (int j = 0; j < N_ENTRIES; j++) begin
            if (csr_is_addr) begin
                if (int'(csr_idx) == j) begin
                    csr_rdata = entry_addr[j*XLEN +: XLEN];
                end
            end else if (int'(csr_idx) == j / BPW) begin
                csr_rdata[(j % BPW)*CFG_W +: CFG_W] = entry_cfg[j*CFG_W +: CFG_W];
            end
        end
    end

endmodule

// File: rtl/pmp_regfile_chk.sv
// Property checker for pmp_regfile, attached by bind. It watches the ports
// and the effective-lock vector that the lock chain drives.
module pmp_regfile_chk #(
    parameter int N_ENTRIES = 8,
    parameter int XLEN      = 32,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      csr_we,
    input logic                      csr_is_addr,
    input logic [IDX_W-1:0]          csr_idx,
    input logic [XLEN-1:0]           csr_rdata,
    input logic [N_ENTRIES*8-1:0]    entry_cfg,
    input logic [N_ENTRIES*XLEN-1:0] entry_addr,
    input logic [CNT_W-1:0]          active_count,
    input logic [N_ENTRIES-1:0]      entry_locked
);

    // R1: one cycle after a reset cycle, every register is clear.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (active_count == '0 && entry_cfg == '0 && entry_addr == '0));

    // R5: the top entry is locked only through its own lock bit.
    p_top_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_locked[N_ENTRIES-1] |-> entry_cfg[(N_ENTRIES-1)*8 + 7]);

    // R7: out-of-range address writes change nothing.
    p_oob_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_is_addr && int'(csr_idx) >= N_ENTRIES) |=> $stable(entry_addr));

    // R7: out-of-range address reads return zero.
    p_oob_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_is_addr && int'(csr_idx) >= N_ENTRIES) |-> (csr_rdata == '0));

    // R10: the count never exceeds the entry count and holds while idle.
    p_count_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(active_count) <= N_ENTRIES);
    p_idle_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> $stable(active_count));

    if (XLEN == 64) begin : g_odd
        // R8: odd configuration words are not writable at XLEN 64.
        p_odd_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && !csr_is_addr && csr_idx[0]) |=> $stable(entry_cfg));
    end

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_ent
        // R3/R4: a locked entry keeps its configuration byte.
        p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            entry_locked[j] |=> $stable(entry_cfg[j*8 +: 8]));
        // R4: a locked entry keeps its address register.
        p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            entry_locked[j] |=> $stable(entry_addr[j*XLEN +: XLEN]));
        // R3: a lock bit stays set until reset.
        p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            entry_cfg[j*8 + 7] |=> entry_cfg[j*8 + 7]);
    end

endmodule

bind pmp_regfile pmp_regfile_chk #(
    .N_ENTRIES (N_ENTRIES),
    .XLEN      (XLEN),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_we       (csr_we),
    .csr_is_addr  (csr_is_addr),
    .csr_idx      (csr_idx),
    .csr_rdata    (csr_rdata),
    .entry_cfg    (entry_cfg),
    .entry_addr   (entry_addr),
    .active_count (active_count),
    .entry_locked (entry_locked)
);

// File: tb/sim_pmp_regfile.sv
`timescale 1ns/1ps
// Bench for pmp_regfile: a vector table on a 32-bit, 8-entry instance, then
// directed reset, count and lock checks, plus a 64-bit 16-entry instance.
module sim_pmp_regfile;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // ---------------- 32-bit, 8-entry instance ----------------
    logic        we0 = 1'b0;
    logic        isa0 = 1'b0;
    logic [5:0]  idx0 = '0;
    logic [31:0] wd0 = '0;
    logic [31:0] rd0;
    logic [63:0] cfg0;
    logic [255:0] adr0;
    logic [3:0]  cnt0;

    pmp_regfile #(.N_ENTRIES(8), .XLEN(32), .IDX_W(6)) u0 (
        .clk (clk), .rst_n (rst_n), .csr_we (we0), .csr_is_addr (isa0),
        .csr_idx (idx0), .csr_wdata (wd0), .csr_rdata (rd0),
        .entry_cfg (cfg0), .entry_addr (adr0), .active_count (cnt0)
    );

    // ---------------- 64-bit, 16-entry instance ----------------
    logic        we1 = 1'b0;
    logic        isa1 = 1'b0;
    logic [5:0]  idx1 = '0;
    logic [63:0] wd1 = '0;
    logic [63:0] rd1;
    logic [127:0] cfg1;
    logic [1023:0] adr1;
    logic [4:0]  cnt1;

    pmp_regfile #(.N_ENTRIES(16), .XLEN(64), .IDX_W(6)) u1 (
        .clk (clk), .rst_n (rst_n), .csr_we (we1), .csr_is_addr (isa1),
        .csr_idx (idx1), .csr_wdata (wd1), .csr_rdata (rd1),
        .entry_cfg (cfg1), .entry_addr (adr1), .active_count (cnt1)
    );

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle on u0.
    task automatic wr0(input logic a, input logic [5:0] i, input logic [31:0] d);
        @(negedge clk);
        we0 = 1'b1; isa0 = a; idx0 = i; wd0 = d;
        @(negedge clk);
        we0 = 1'b0;
    endtask

    // Combinational read on u0, sampled between edges.
    task automatic rdv0(input logic a, input logic [5:0] i, output logic [31:0] d);
        @(negedge clk);
        we0 = 1'b0; isa0 = a; idx0 = i;
        #1;
        d = rd0;
    endtask

    task automatic wr1(input logic a, input logic [5:0] i, input logic [63:0] d);
        @(negedge clk);
        we1 = 1'b1; isa1 = a; idx1 = i; wd1 = d;
        @(negedge clk);
        we1 = 1'b0;
    endtask

    task automatic rdv1(input logic a, input logic [5:0] i, output logic [63:0] d);
        @(negedge clk);
        we1 = 1'b0; isa1 = a; idx1 = i;
        #1;
        d = rd1;
    endtask

    typedef struct packed {
        logic        wr;
        logic        is_addr;
        logic [5:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 6'd0, 32'h1B110900, 32'h0,        4'd2},  // R2 mixed modes
        '{1'b0, 1'b0, 6'd0, 32'h0,        32'h1B110900, 4'd9},  // R9 byte order
        '{1'b1, 1'b1, 6'd0, 32'h00001000, 32'h0,        4'd2},
        '{1'b0, 1'b1, 6'd0, 32'h0,        32'h00001000, 4'd9},  // R9 address read
        '{1'b1, 1'b1, 6'd7, 32'h0000ABCD, 32'h0,        4'd2},
        '{1'b0, 1'b1, 6'd7, 32'h0,        32'h0000ABCD, 4'd9},
        '{1'b1, 1'b1, 6'd9, 32'h00000005, 32'h0,        4'd7},  // R7 beyond range
        '{1'b0, 1'b1, 6'd9, 32'h0,        32'h0,        4'd7},
        '{1'b1, 1'b0, 6'd2, 32'hFFFFFFFF, 32'h0,        4'd7},
        '{1'b0, 1'b0, 6'd2, 32'h0,        32'h0,        4'd7},
        '{1'b0, 1'b0, 6'd1, 32'h0,        32'h0,        4'd7},  // R7 no spill
        '{1'b1, 1'b0, 6'd1, 32'h00880080, 32'h0,        4'd2},  // lock e4, TOR lock e6
        '{1'b0, 1'b0, 6'd1, 32'h0,        32'h00880080, 4'd2},
        '{1'b1, 1'b0, 6'd1, 32'h19191919, 32'h0,        4'd6},  // R6 per-byte filter
        '{1'b0, 1'b0, 6'd1, 32'h0,        32'h19880080, 4'd6},
        '{1'b1, 1'b1, 6'd4, 32'h00000044, 32'h0,        4'd3},  // R3 own lock
        '{1'b0, 1'b1, 6'd4, 32'h0,        32'h0,        4'd3},
        '{1'b1, 1'b1, 6'd5, 32'h00000055, 32'h0,        4'd4},  // R4 TOR neighbour
        '{1'b0, 1'b1, 6'd5, 32'h0,        32'h0,        4'd4},
        '{1'b1, 1'b1, 6'd6, 32'h00000066, 32'h0,        4'd3},
        '{1'b0, 1'b1, 6'd6, 32'h0,        32'h0,        4'd3},
        '{1'b1, 1'b1, 6'd7, 32'h00000077, 32'h0,        4'd5},  // R5 top entry free
        '{1'b0, 1'b1, 6'd7, 32'h0,        32'h00000077, 4'd5},
        '{1'b1, 1'b1, 6'd3, 32'h00000033, 32'h0,        4'd4},  // R4 locked OFF above
        '{1'b0, 1'b1, 6'd3, 32'h0,        32'h00000033, 4'd4},
        '{1'b1, 1'b1, 6'd0, 32'h00002000, 32'h0,        4'd4},  // R4 unlocked TOR above
        '{1'b0, 1'b1, 6'd0, 32'h0,        32'h00002000, 4'd4}
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r32;
        logic [63:0] r64;
        string tag;

        repeat (3) @(negedge clk);
        // R1: reset state at the ports.
        check("R1 cfg", 64'(cfg0), 64'h0);
        check("R1 addr", 64'(adr0 == '0), 64'h1);
        check("R1 count", 64'(cnt0), 64'h0);
        rst_n = 1'b1;
        rdv0(1'b0, 6'd0, r32);
        check("R1 read", 64'(r32), 64'h0);

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                wr0(VECS[v].is_addr, VECS[v].idx, VECS[v].data);
            end else begin
                rdv0(VECS[v].is_addr, VECS[v].idx, r32);
                tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
                check(tag, 64'(r32), 64'(VECS[v].exp));
            end
        end

        // R10: modes e1 TOR, e2 NA4, e3 NAPOT, e6 TOR, e7 NAPOT.
        check("R10 count", 64'(cnt0), 64'd5);
        // R5: the top entry took its new byte at the port.
        check("R5 top cfg", 64'(cfg0[63:56]), 64'h19);
        // R10: a rejected write to e4..e6 plus a clear of e7 drops the count to 4.
        wr0(1'b0, 6'd1, 32'h00000000);
        #1;
        check("R10 after partial reject", 64'(cnt0), 64'd4);
        check("R3 e6 cfg kept", 64'(cfg0[55:48]), 64'h88);
        check("R3 e4 addr kept", 64'(adr0[4*32 +: 32]), 64'h0);
        // R10: a fully rejected address write leaves the count alone.
        wr0(1'b1, 6'd5, 32'hDEAD0000);
        #1;
        check("R10 count after reject", 64'(cnt0), 64'd4);

        // R1: reset clears settings and locks.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 cfg after reset", 64'(cfg0), 64'h0);
        check("R1 count after reset", 64'(cnt0), 64'h0);
        wr0(1'b1, 6'd4, 32'h00000044);
        rdv0(1'b1, 6'd4, r32);
        check("R1 lock cleared", 64'(r32), 64'h44);

        // R8: odd configuration word on the 64-bit instance is ignored.
        wr1(1'b0, 6'd1, 64'h0909090909090909);
        rdv1(1'b0, 6'd1, r64);
        check("R8 odd word", r64, 64'h0);
        check("R8 count", 64'(cnt1), 64'h0);
        // R9: even word lands, lowest entry in the lowest byte.
        wr1(1'b0, 6'd0, 64'h1B11090900000009);
        rdv1(1'b0, 6'd0, r64);
        check("R9 wide read", r64, 64'h1B11090900000009);
        check("R2 wide lane e0", 64'(cfg1[7:0]), 64'h09);
        check("R10 wide count", 64'(cnt1), 64'd5);
        // R7: a group entirely beyond range is dropped.
        wr1(1'b0, 6'd2, 64'hFFFFFFFFFFFFFFFF);
        #1;
        check("R7 wide beyond", 64'(cnt1), 64'd5);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule